// File: doc/BRIEF.md
# UART Peripheral with Register Bus and FIFOs

This block is a serial port that a processor reaches through a small byte-addressed register bus. It sends and receives 8-bit asynchronous frames with one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A 10-bit divider sets the rate of a 16x oversampling tick. Each direction has a small FIFO. One data address serves both directions: a read pops the receive FIFO, and a write pushes the transmit FIFO.

Software configures the block through a control word. The control word holds the divider, an enable for the receive interrupt and a soft reset. Software polls a status word for FIFO state, transmitter activity, the receiver's live bit counter and three error flags. The framing error flag, the transmit overrun flag and the receive overrun flag stay set until software sets the soft reset bit and then clears it. The interrupt line tells the processor that received bytes are waiting.

Top module: `uart_periph`

## Requirements
- R1: After reset the status word (offset 0x02) reads 0x0002, meaning only bit 1 (transmit FIFO can accept data) is set. The serial output is high and the interrupt is low.
- R2: Control bits 9:0 (offset 0x00) hold a divider value D. One oversampling tick lasts D+1 clocks and one bit lasts 16 ticks, so a 0x00 byte holds the line low for 9*16*(D+1) clocks.
- R3: A byte written to offset 0x04 (bits 7:0) is sent as a low start bit, then the data bits LSB first, then a high stop bit. Status bit 2 is 1 while a frame is in progress and 0 once it ends.
- R4: A received frame can be read at offset 0x04, with the data in bits 7:0 and bit 8 = 1. Each read pops one byte. Reading an empty FIFO returns bit 8 = 0. Status bit 0 is 1 while received data is waiting.
- R5: The transmit FIFO holds 4 bytes in addition to the byte being shifted. Status bit 1 drops to 0 when the FIFO is full, and queued bytes are sent in the order they were written.
- R6: A write to offset 0x04 while the transmit FIFO is full is discarded and sets status bit 6. Bit 6 stays set until the soft reset.
- R7: A byte that completes while the receive FIFO already holds 4 bytes is dropped, and the stored bytes are kept. This event sets status bit 7, which stays set until the soft reset.
- R8: A frame whose stop bit is sampled low sets status bit 5, and its data byte is still stored. Bit 5 stays set through later good frames until the soft reset.
- R9: While control bit 15 is 1, both FIFOs, all flags and both shifters are held cleared, and writes to the data address and incoming frames have no effect. Clearing the bit resumes operation, with the divider and interrupt enable kept.
- R10: The interrupt output is high exactly while control bit 14 is 1 and the receive FIFO is not empty, and it follows these conditions one clock later.
- R11: Status bits 10:8 show how many data bits of the current frame the receiver has sampled, and read 0 when the receiver is idle.
- R12: A low pulse on the serial input that is shorter than half a bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address (0x00 control, 0x02 status, 0x04 data) |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | One-cycle read strobe; read data is valid the next cycle |
| bus_rdata | output | 16 | Registered read data |
| rxd_i | input | 1 | Serial input, idle high |
| txd_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench builds the block with the default 4-entry FIFOs and a 10-bit divider field. It programs divider 1, so one bit lasts 32 clocks and a full frame lasts 320 clocks. With bit times this short, FIFO overflow in both directions, sticky flags across several frames and the mid-frame bit counter can all be exercised in a few thousand cycles. A single run at divider 3 checks that the bit time scales exactly with the divider.

// File: rtl/uart_periph_pkg.sv
package uart_periph_pkg;
  localparam int OSR = 16;
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_STAT = 8'h02;
  localparam logic [7:0] ADDR_DATA = 8'h04;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [PW-1:0]    level;
  logic             do_push, do_pop;

  assign level   = wptr_q - rptr_q;
  assign empty   = (level == '0);
  assign full    = (level == PW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  p_level_bound_r5: assert property (@(posedge clk) disable iff (srst)
    level <= PW'(DEPTH));
  p_full_holds_r7: assert property (@(posedge clk) disable iff (srst)
    full && !pop |=> full);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DBITS = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             avail,
  input  logic [DBITS-1:0] data,
  output logic             pop,
  output logic             txd,
  output logic             busy
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(DBITS + 2);

  logic [DBITS:0]  sh_q;
  logic [TW-1:0]   tcnt_q;
  logic [BW-1:0]   bidx_q;
  logic            busy_q, txd_q;

  assign pop  = !busy_q && avail && tick;
  assign txd  = txd_q;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      tcnt_q <= '0;
      bidx_q <= '0;
    end else if (pop) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      sh_q   <= {1'b1, data};
      tcnt_q <= '0;
      bidx_q <= '0;
    end else if (busy_q && tick) begin
      if (tcnt_q == TW'(OSR - 1)) begin
        tcnt_q <= '0;
        if (bidx_q == BW'(DBITS + 1)) begin
          busy_q <= 1'b0;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[DBITS:1]};
          bidx_q <= bidx_q + 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  p_start_bit_r3: assert property (@(posedge clk) disable iff (srst)
    pop |=> busy_q && !txd_q);
  p_idle_line_r3: assert property (@(posedge clk) disable iff (srst)
    $fell(busy_q) |-> txd_q);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_periph_pkg::*;
#(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             rxd,
  output logic             push,
  output logic [DBITS-1:0] data,
  output logic             ferr,
  output logic [$clog2(DBITS)-1:0] bitcnt
);
  localparam int TW = $clog2(OSR);
  localparam int CW = $clog2(DBITS);

  rx_state_t        st_q;
  logic [2:0]       sync_q;
  logic [TW-1:0]    tcnt_q;
  logic [CW-1:0]    bcnt_q;
  logic [DBITS-1:0] sh_q;
  logic             push_q, ferr_q;
  logic             line;

  assign line   = sync_q[1];
  assign push   = push_q;
  assign ferr   = ferr_q;
  assign data   = sh_q;
  assign bitcnt = bcnt_q;

  always_ff @(posedge clk) begin
    if (srst) sync_q <= '1;
    else      sync_q <= {sync_q[1:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      ferr_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          tcnt_q <= '0;
          bcnt_q <= '0;
          if (sync_q[2] && !line) st_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt_q == TW'(OSR / 2 - 1)) begin
            tcnt_q <= '0;
            st_q   <= line ? RX_IDLE : RX_DATA;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (tcnt_q == TW'(OSR - 1)) begin
            tcnt_q <= '0;
            sh_q   <= {line, sh_q[DBITS-1:1]};
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == CW'(DBITS - 1)) st_q <= RX_STOP;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: if (tick) begin
          if (tcnt_q == TW'(OSR - 1)) begin
            push_q <= 1'b1;
            ferr_q <= !line;
            st_q   <= RX_IDLE;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
      endcase
    end
  end

  p_push_single_r4: assert property (@(posedge clk) disable iff (srst)
    push_q |=> !push_q);
  p_idle_count_r11: assert property (@(posedge clk) disable iff (srst)
    push_q |-> bcnt_q == '0);
endmodule

// File: rtl/uart_periph.sv
module uart_periph
  import uart_periph_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [15:0] bus_rdata,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        irq_o
);
  localparam int DBITS = 8;
  localparam int CW    = $clog2(DBITS);

  logic [DIV_W-1:0] div_q, bcnt_q;
  logic             ie_q, sres_q, srst, tick_q;
  logic             frerr_q, txovr_q, rxovr_q, irq_q;
  logic [15:0]      rdata_q;
  logic             tx_wr, rx_rd;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic             tx_empty, tx_full, tx_pop, tx_busy;
  logic             rx_empty, rx_full, rx_push, rx_ferr;
  logic [CW-1:0]    rx_bits;

  assign srst  = rst || sres_q;
  assign tx_wr = bus_we && (bus_addr == ADDR_DATA);
  assign rx_rd = bus_re && (bus_addr == ADDR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      ie_q   <= 1'b0;
      sres_q <= 1'b0;
    end else if (bus_we && bus_addr == ADDR_CTRL) begin
      div_q  <= bus_wdata[DIV_W-1:0];
      ie_q   <= bus_wdata[14];
      sres_q <= bus_wdata[15];
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      bcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (bcnt_q == div_q);
      bcnt_q <= (bcnt_q == div_q) ? '0 : bcnt_q + 1'b1;
    end
  end

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .srst(srst), .push(tx_wr), .din(bus_wdata[7:0]),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .srst(srst), .push(rx_push), .din(rx_byte),
    .pop(rx_rd), .head(rx_head), .empty(rx_empty), .full(rx_full));

  uart_tx #(.DBITS(DBITS), .OSR(OSR)) u_tx (
    .clk(clk), .srst(srst), .tick(tick_q), .avail(!tx_empty),
    .data(tx_head), .pop(tx_pop), .txd(txd_o), .busy(tx_busy));

  uart_rx #(.DBITS(DBITS)) u_rx (
    .clk(clk), .srst(srst), .tick(tick_q), .rxd(rxd_i),
    .push(rx_push), .data(rx_byte), .ferr(rx_ferr), .bitcnt(rx_bits));

  always_ff @(posedge clk) begin
    if (srst) begin
      frerr_q <= 1'b0;
      txovr_q <= 1'b0;
      rxovr_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (rx_push && rx_ferr) frerr_q <= 1'b1;
      if (tx_wr && tx_full)   txovr_q <= 1'b1;
      if (rx_push && rx_full) rxovr_q <= 1'b1;
      irq_q <= ie_q && !rx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        ADDR_CTRL: rdata_q <= {sres_q, ie_q, (14 - DIV_W)'(0), div_q};
        ADDR_STAT: rdata_q <= {5'b0, 3'(rx_bits), rxovr_q, txovr_q, frerr_q,
                               2'b0, tx_busy, !tx_full, !rx_empty};
        ADDR_DATA: rdata_q <= {7'b0, !rx_empty, rx_head};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  p_frerr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    frerr_q && !srst |=> frerr_q);
  p_txovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    txovr_q && !srst |=> txovr_q);
  p_rxovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    rxovr_q && !srst |=> rxovr_q);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (srst)
    irq_o |-> $past(ie_q) && $past(!rx_empty));
  p_hold_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sres_q |=> !frerr_q && !txovr_q && !rxovr_q && txd_o);
endmodule

// File: tb/uart_periph_bench.sv
module uart_periph_bench;
  localparam int BIT_CLK = 32;  // divider 1: 16 ticks * 2 clocks

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_periph u_uart_periph (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rxd_i(rxd), .txd_o(txd), .irq_o(irq));

  localparam logic [7:0] VEC_IN  [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
  localparam logic [15:0] VEC_EXP [6] = '{16'h0100, 16'h01FF, 16'h01A5,
                                          16'h015A, 16'h0101, 16'h0180};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv);
    logic [9:0] fr;
    fr = {stopv, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = fr[i];
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic capture_tx(output logic [7:0] b, output bit ok);
    int n;
    n = 0;
    ok = 1'b0;
    b = '0;
    @(negedge clk);
    while (txd && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!txd) begin
      repeat (BIT_CLK / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT_CLK) @(negedge clk);
        b[i] = txd;
      end
      repeat (BIT_CLK) @(negedge clk);
      ok = txd;
    end
  endtask

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [7:0]  b;
    bit          ok;
    int          lows;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(8'h02, rd);
    check(rd == 16'h0002, "R1 status after reset", rd, 16'h0002);
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(irq == 1'b0, "R1 irq low", irq, 0);

    bus_write(8'h00, 16'h0001);
    bus_read(8'h00, rd);
    check(rd == 16'h0001, "R2 control readback", rd, 16'h0001);

    // vector table: transmit then receive each byte
    for (int v = 0; v < 6; v++) begin
      bus_write(8'h04, {8'h00, VEC_IN[v]});
      capture_tx(b, ok);
      check(ok && b == VEC_IN[v], "R3 tx frame", {ok, b}, {1'b1, VEC_IN[v]});
      send_rx(VEC_IN[v], 1'b1);
      bus_read(8'h04, rd);
      check(rd == VEC_EXP[v], "R4 rx data", rd, VEC_EXP[v]);
      bus_read(8'h04, rd);
      check(rd[8] == 1'b0, "R4 pop empties", rd[8], 0);
    end
    repeat (40) @(negedge clk);

    // R3 busy flag
    bus_write(8'h04, 16'h003C);
    fork
      capture_tx(b, ok);
      begin
        repeat (40) @(negedge clk);
        bus_read(8'h02, rd);
        check(rd[2] == 1'b1, "R3 busy during frame", rd[2], 1);
      end
    join
    check(ok && b == 8'h3C, "R3 tx 0x3C", b, 8'h3C);
    repeat (40) @(negedge clk);
    bus_read(8'h02, rd);
    check(rd[2] == 1'b0, "R3 busy clears", rd[2], 0);

    // R2 divider scaling
    bus_write(8'h00, 16'h0003);
    bus_write(8'h04, 16'h0000);
    count_low(1000, lows);
    check(lows == 576, "R2 low time at divider 3", lows, 576);
    bus_write(8'h00, 16'h0001);

    // R11 live bit counter
    fork
      send_rx(8'h55, 1'b1);
      begin
        repeat (BIT_CLK * 4 + 8) @(negedge clk);
        bus_read(8'h02, rd);
        check(rd[10:8] == 3'd3, "R11 bit count mid-frame", rd[10:8], 3);
      end
    join
    bus_read(8'h02, rd);
    check(rd[10:8] == 3'd0, "R11 bit count idle", rd[10:8], 0);
    bus_read(8'h04, rd);
    check(rd == 16'h0155, "R4 rx 0x55", rd, 16'h0155);

    // R12 glitch rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    bus_read(8'h02, rd);
    check(rd == 16'h0002, "R12 glitch ignored", rd, 16'h0002);

    // R5 / R6 transmit FIFO depth and overrun
    for (int i = 0; i < 6; i++) bus_write(8'h04, 16'(8'h11 + i));
    bus_read(8'h02, rd);
    check(rd == 16'h0044, "R5 R6 full and overrun", rd, 16'h0044);
    for (int i = 0; i < 5; i++) begin
      capture_tx(b, ok);
      check(ok && b == 8'(8'h11 + i), "R5 tx order", b, 8'h11 + i);
    end
    count_low(400, lows);
    check(lows == 0, "R6 dropped byte not sent", lows, 0);
    bus_read(8'h02, rd);
    check(rd == 16'h0042, "R6 overrun sticky", rd, 16'h0042);

    // R7 receive FIFO overrun
    for (int i = 0; i < 5; i++) send_rx(8'(8'h21 + i), 1'b1);
    bus_read(8'h02, rd);
    check(rd == 16'h00C3, "R7 rx overrun flag", rd, 16'h00C3);
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h04, rd);
      check(rd == 16'(16'h0121 + i), "R7 kept bytes", rd, 16'h0121 + i);
    end
    bus_read(8'h04, rd);
    check(rd[8] == 1'b0, "R7 fifth byte dropped", rd[8], 0);

    // R8 framing error
    send_rx(8'h77, 1'b0);
    bus_read(8'h02, rd);
    check(rd[5] == 1'b1, "R8 framing error set", rd[5], 1);
    bus_read(8'h04, rd);
    check(rd == 16'h0177, "R8 byte stored", rd, 16'h0177);
    send_rx(8'h78, 1'b1);
    bus_read(8'h04, rd);
    check(rd == 16'h0178, "R8 good frame after error", rd, 16'h0178);
    bus_read(8'h02, rd);
    check(rd[5] == 1'b1, "R8 framing error sticky", rd[5], 1);

    // R10 interrupt
    bus_write(8'h00, 16'h4001);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R10 irq empty fifo", irq, 0);
    send_rx(8'h42, 1'b1);
    check(irq == 1'b1, "R10 irq data waiting", irq, 1);
    bus_write(8'h00, 16'h0001);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 irq disabled", irq, 0);
    bus_write(8'h00, 16'h4001);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R10 irq re-enabled", irq, 1);
    bus_read(8'h04, rd);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 irq after pop", irq, 0);

    // R9 soft reset
    send_rx(8'h66, 1'b1);
    bus_write(8'h00, 16'h8001);
    bus_read(8'h02, rd);
    check(rd == 16'h0002, "R9 flags and fifos cleared", rd, 16'h0002);
    bus_write(8'h04, 16'h0099);
    send_rx(8'h33, 1'b1);
    bus_read(8'h02, rd);
    check(rd == 16'h0002, "R9 input ignored in reset", rd, 16'h0002);
    check(lows == 0 && txd, "R9 txd high in reset", txd, 1);
    bus_write(8'h00, 16'h4001);
    count_low(400, lows);
    check(lows == 0, "R9 write during reset discarded", lows, 0);
    bus_read(8'h00, rd);
    check(rd == 16'h4001, "R9 control kept", rd, 16'h4001);
    check(irq == 1'b0, "R9 rx byte during reset discarded", irq, 0);
    bus_write(8'h04, 16'h005A);
    capture_tx(b, ok);
    check(ok && b == 8'h5A, "R9 resumes after release", b, 8'h5A);

    repeat (40) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule